// File: doc/BRIEF.md
# Serial-Priority Bus Grant Arbiter

This block decides which of several devices on a shared bus becomes the next bus owner. Every device can pull a common request line. A central controller answers that line with a single grant pulse, but only while the shared busy line is idle. The grant then passes combinationally through a chain of device slices. Slice 0 sits nearest the controller. A slice with no pending request passes the grant on to the next slice. A slice with a pending request keeps the grant and becomes the owner.

The owning slice holds the busy line for its whole tenure and enables its bus connection, shown on a one-hot owner output. In the first cycle of the tenure it places its own interrupt vector on the vector data lines. Priority comes only from chain position, so software cannot change it. A low-index device that requests all the time can keep higher-index devices off the bus forever.

Requests are sampled once, in the cycle in which the controller decides to grant. A request that appears while the grant is travelling along the chain therefore cannot take ownership partway down the chain.

Top module: `serial_grant_arbiter`

## Requirements
- R1: `bus_req` is high in exactly those cycles in which at least one bit of `dev_req` is high, with no register delay.
- R2: The grant decision is made in a cycle in which `bus_req` is high, `bus_busy` is low and `bus_grant` is low. `bus_grant` is then high in the next cycle, for exactly one cycle.
- R3: `bus_grant` is never high while `bus_busy` is high. After a tenure ends, `bus_grant` stays low in the first cycle in which `bus_busy` is low again.
- R4: The requests that compete for a grant are the `dev_req` bits present in the decision cycle. A request raised only in the grant cycle does not win. A request dropped in the grant cycle still wins. The grant always stops inside the chain.
- R5: In the cycle after `bus_grant`, `owner` is one-hot. Its set bit is the lowest-index slice among the sampled requesters, where bit i is slice i and slice 0 is nearest the controller. `bus_busy` is high from that cycle on. At most one owner bit is ever set.
- R6: An owner keeps `owner` and `bus_busy` until a cycle in which its own `dev_done` bit is high. In the next cycle `owner` is zero and `bus_busy` is low. `dev_done` bits of slices that do not own the bus have no effect.
- R7: `vec_valid` is high for exactly one cycle, the first cycle of each tenure. In that cycle `vec_data` equals (VEC_BASE + i*VEC_STEP) modulo 2^VEC_W for owning slice i. `vec_data` is zero whenever `vec_valid` is low.
- R8: Priority is fixed. If slice 0 requests continuously, every tenure goes to slice 0 and no higher-index requester is ever served.
- R9: While `rst_n` is low, `bus_grant`, `bus_busy`, `owner`, `vec_valid` and `vec_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | N_SLICES | Per-device bus request, bit i belongs to slice i |
| dev_done | input | N_SLICES | Per-device end of tenure, honoured only from the owner |
| bus_req | output | 1 | Shared request line, OR of all requests |
| bus_grant | output | 1 | Controller grant pulse into slice 0 |
| bus_busy | output | 1 | Shared busy line, high while any slice owns the bus |
| owner | output | N_SLICES | One-hot bus-connection enable of the owning slice |
| vec_valid | output | 1 | Vector strobe in the first cycle of a tenure |
| vec_data | output | VEC_W | Interrupt vector of the new owner |

## Verification
Two events can fall in the same cycle: an owner ending its tenure, and a new request arriving or a request changing while a grant is already in flight. The bench forces the first case by holding further requests high while the owner asserts `dev_done`. It then judges that a gap cycle with `bus_busy` low and `bus_grant` low comes before the next grant. It forces the second case by raising or dropping a request in the grant cycle itself, and compares the resulting owner and vector against a reference model built from the sampled requests. Random request and done patterns, including done bits from non-owners, are compared cycle by cycle against that model.

// File: rtl/sga_pkg.sv
package sga_pkg;

  // Vector for slice idx: base plus idx steps, full 32-bit sum (caller truncates)
  function automatic logic [31:0] slice_vector(input int unsigned base,
                                               input int unsigned step,
                                               input int unsigned idx);
    return 32'(base + step * idx);
  endfunction

  // Number of bits needed to index n slices
  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sga_ctrl.sv
// Central controller: decides a grant when the shared request is up and the
// bus is idle, then issues a single-cycle grant pulse into the chain.
module sga_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_req,
  input  logic bus_busy,
  output logic decide,
  output logic grant
);

  logic grant_q;

  // Decision cycle: a request is pending, the bus is idle, and no grant is travelling
  assign decide = bus_req & ~bus_busy & ~grant_q;

  always_ff @(posedge clk) begin
    if (!rst_n) grant_q <= 1'b0;
    else        grant_q <= decide;
  end

  assign grant = grant_q;

endmodule

// File: rtl/sga_slice.sv
// One chain slice: samples its request at decision time, absorbs or passes
// the grant, and holds ownership until its own done strobe.
module sga_slice (
  input  logic clk,
  input  logic rst_n,
  input  logic decide,
  input  logic req,
  input  logic done,
  input  logic grant_in,
  output logic grant_out,
  output logic take,
  output logic own
);

  logic sampled_q;
  logic own_q;

  // Request snapshot valid only in the grant cycle
  always_ff @(posedge clk) begin
    if (!rst_n) sampled_q <= 1'b0;
    else        sampled_q <= decide & req;
  end

  assign take      = grant_in & sampled_q;
  assign grant_out = grant_in & ~sampled_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            own_q <= 1'b0;
    else if (take)         own_q <= 1'b1;
    else if (own_q & done) own_q <= 1'b0;
  end

  assign own = own_q;

endmodule

// File: rtl/sga_vector.sv
// Vector driver: registers the vector of the slice that took the grant.
module sga_vector #(
  parameter int unsigned N_SLICES = 5,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_BASE = 32'h40,
  parameter int unsigned VEC_STEP = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_SLICES-1:0] take,
  output logic                vec_valid,
  output logic [VEC_W-1:0]    vec_data
);

  logic [VEC_W-1:0] lut [N_SLICES];
  logic [VEC_W-1:0] sel;
  logic             any_take;

  for (genvar i = 0; i < N_SLICES; i++) begin : g_lut
    logic [31:0] full;
    assign full   = sga_pkg::slice_vector(VEC_BASE, VEC_STEP, i);
    assign lut[i] = full[VEC_W-1:0];
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < N_SLICES; i++) begin
      if (take[i]) sel = sel | lut[i];
    end
  end

  assign any_take = |take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_valid <= 1'b0;
      vec_data  <= '0;
    end else begin
      vec_valid <= any_take;
      vec_data  <= any_take ? sel : '0;
    end
  end

endmodule

// File: rtl/serial_grant_arbiter.sv
// Top: controller plus a serial chain of slices; priority by chain position.
module serial_grant_arbiter #(
  parameter int unsigned N_SLICES = 5,
  parameter int unsigned VEC_W    = 8,
  parameter int unsigned VEC_BASE = 32'h40,
  parameter int unsigned VEC_STEP = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_SLICES-1:0] dev_req,
  input  logic [N_SLICES-1:0] dev_done,
  output logic                bus_req,
  output logic                bus_grant,
  output logic                bus_busy,
  output logic [N_SLICES-1:0] owner,
  output logic                vec_valid,
  output logic [VEC_W-1:0]    vec_data
);

  // Named internal events for the checker
  logic                decide;
  logic [N_SLICES:0]   grant_chain;
  logic [N_SLICES-1:0] take_vec;
  logic                grant_tail;

  assign bus_req  = |dev_req;
  assign bus_busy = |owner;

  sga_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_busy (bus_busy),
    .decide   (decide),
    .grant    (bus_grant)
  );

  assign grant_chain[0] = bus_grant;

  for (genvar i = 0; i < N_SLICES; i++) begin : g_slice
    sga_slice u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .decide    (decide),
      .req       (dev_req[i]),
      .done      (dev_done[i]),
      .grant_in  (grant_chain[i]),
      .grant_out (grant_chain[i+1]),
      .take      (take_vec[i]),
      .own       (owner[i])
    );
  end

  assign grant_tail = grant_chain[N_SLICES];

  sga_vector #(
    .N_SLICES (N_SLICES),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE),
    .VEC_STEP (VEC_STEP)
  ) u_vec (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take_vec),
    .vec_valid (vec_valid),
    .vec_data  (vec_data)
  );

endmodule

// File: rtl/sga_checker.sv
module sga_checker #(
  parameter int unsigned N_SLICES = 5,
  parameter int unsigned VEC_W    = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic [N_SLICES-1:0] dev_done,
  input logic                bus_grant,
  input logic                bus_busy,
  input logic [N_SLICES-1:0] owner,
  input logic                vec_valid,
  input logic [VEC_W-1:0]    vec_data,
  input logic [N_SLICES-1:0] take_vec,
  input logic                grant_tail
);

  assert_grant_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_grant |=> !bus_grant);

  assert_no_grant_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |-> !bus_grant);

  assert_gap_after_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_busy) |-> !bus_grant);

  assert_tail_absorbed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_grant |-> !grant_tail);

  assert_grant_makes_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_grant |=> (bus_busy && $onehot(owner)));

  assert_single_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(owner));

  assert_single_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_vec));

  assert_owner_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_busy && ((owner & dev_done) == '0)) |=> $stable(owner));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((owner & dev_done) != '0) |=> !bus_busy);

  assert_vec_on_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_busy) |-> vec_valid);

  assert_vec_in_tenure_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (bus_busy && $past(bus_grant)));

  assert_vec_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> (vec_data == '0));

endmodule

bind serial_grant_arbiter sga_checker #(
  .N_SLICES (N_SLICES),
  .VEC_W    (VEC_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dev_done   (dev_done),
  .bus_grant  (bus_grant),
  .bus_busy   (bus_busy),
  .owner      (owner),
  .vec_valid  (vec_valid),
  .vec_data   (vec_data),
  .take_vec   (take_vec),
  .grant_tail (grant_tail)
);

// File: tb/serial_grant_arbiter_tb.sv
`timescale 1ns/1ps
module serial_grant_arbiter_tb;

  localparam int N  = 5;
  localparam int VW = 8;
  localparam int VB = 'h40;
  localparam int VS = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  dev_req = '0;
  logic [N-1:0]  dev_done = '0;
  logic          bus_req, bus_grant, bus_busy, vec_valid;
  logic [N-1:0]  owner;
  logic [VW-1:0] vec_data;

  always #4 clk = ~clk;  // 125 MHz

  serial_grant_arbiter #(.N_SLICES(N), .VEC_W(VW), .VEC_BASE(VB), .VEC_STEP(VS)) u_dut (
    .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .dev_done(dev_done),
    .bus_req(bus_req), .bus_grant(bus_grant), .bus_busy(bus_busy),
    .owner(owner), .vec_valid(vec_valid), .vec_data(vec_data)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // Reference model state
  logic          m_grant = 0;
  logic [N-1:0]  m_snap = '0;
  logic [N-1:0]  m_owner = '0;
  logic          m_vv = 0;
  logic [VW-1:0] m_vd = '0;

  function automatic logic [VW-1:0] exp_vec(input int idx);
    int acc = VB;
    for (int k = 0; k < idx; k++) acc += VS;
    return acc[VW-1:0];
  endfunction

  function automatic int first_req(input logic [N-1:0] v);
    for (int k = 0; k < N; k++) if (v[k]) return k;
    return -1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: apply inputs at negedge, compare outputs, advance model
  task automatic step(input logic [N-1:0] req, input logic [N-1:0] done);
    logic issue;
    int w;
    @(negedge clk);
    dev_req  = req;
    dev_done = done;
    #1;
    chk("R1 bus_req", 32'(bus_req), 32'(|req));
    chk("R2 bus_grant", 32'(bus_grant), 32'(m_grant));
    chk("R5 owner", 32'(owner), 32'(m_owner));
    chk("R6 bus_busy", 32'(bus_busy), 32'(|m_owner));
    chk("R7 vec_valid", 32'(vec_valid), 32'(m_vv));
    chk("R7 vec_data", 32'(vec_data), 32'(m_vd));
    if (bus_busy) chk("R3 grant while busy", 32'(bus_grant), 32'd0);
    issue = (|req) && (m_owner == '0) && !m_grant;
    w = first_req(m_snap);
    if (m_grant && w >= 0) begin
      m_owner = '0; m_owner[w] = 1'b1;
      m_vv = 1; m_vd = exp_vec(w);
    end else begin
      if ((m_owner & done) != '0) m_owner = '0;
      m_vv = 0; m_vd = '0;
    end
    m_snap  = issue ? req : '0;
    m_grant = issue;
  endtask

  // Watchdog
  initial begin
    #(8 * 100000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] r, d;
    int seen_hi;
    void'($urandom(32'd2718));

    // R9: reset state, with requests present
    dev_req = 5'b10101;
    repeat (3) @(negedge clk);
    #1;
    chk("R9 grant in reset", 32'(bus_grant), 0);
    chk("R9 busy in reset", 32'(bus_busy), 0);
    chk("R9 owner in reset", 32'(owner), 0);
    chk("R9 vec in reset", {31'd0, vec_valid} | 32'(vec_data), 0);
    @(negedge clk);
    dev_req = '0;
    rst_n = 1'b1;

    // R5: slices 1 and 3 request together; slice 1 wins with vector 0x44
    step(5'b01010, '0);           // decision
    step(5'b01010, '0);           // grant cycle
    step(5'b01010, '0);           // tenure start
    chk("R5 nearest wins", 32'(owner), 32'b00010);
    chk("R7 vector slice1", 32'(vec_data), 32'(exp_vec(1)));
    // R6: done from non-owner slice 3 ignored
    step(5'b01000, 5'b01000);
    chk("R6 foreign done ignored", 32'(owner), 32'b00010);
    // R3: owner releases while slice 3 still requests: gap before grant
    step(5'b01000, 5'b00010);
    step(5'b01000, '0);
    chk("R3 gap busy low", 32'(bus_busy), 0);
    chk("R3 gap no grant", 32'(bus_grant), 0);
    step(5'b01000, '0);
    chk("R3 regrant after gap", 32'(bus_grant), 1);
    step('0, '0);
    chk("R5 slice3 owner", 32'(owner), 32'b01000);
    step('0, 5'b01000);
    step('0, '0);

    // R4: slice 0 rises only in the grant cycle; sampled slice 2 wins
    step(5'b00100, '0);
    step(5'b00001, '0);
    step(5'b00001, '0);
    chk("R4 late request loses", 32'(owner), 32'b00100);
    step('0, 5'b00100);
    step('0, '0);
    // R4: slice 4 drops its request in the grant cycle, still wins
    step(5'b10000, '0);
    step('0, '0);
    step('0, '0);
    chk("R4 dropped request wins", 32'(owner), 32'b10000);
    chk("R7 vector slice4", 32'(vec_data), 32'(exp_vec(4)));
    step('0, 5'b10000);
    step('0, '0);

    // R8: slice 0 requests forever, slice 2 never served
    seen_hi = 0;
    for (int t = 0; t < 40; t++) begin
      step(5'b00101, (t % 5 == 4) ? 5'b00001 : '0);
      if (owner[2]) seen_hi++;
    end
    chk("R8 lockout of slice2", seen_hi, 0);
    step('0, 5'b00001);
    step('0, '0);

    // Random traffic against the model
    for (int t = 0; t < 3000; t++) begin
      r = N'($urandom) & N'($urandom);
      d = N'($urandom) & N'($urandom);
      step(r, d);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule